// File: doc/BRIEF.md
# Byte-Bus 16-bit Period Timer

A 16-bit up-counter that an 8-bit processor controls over a byte-wide register bus with four addresses. The counter advances on a tick taken from the block clock or from an external input. That tick is divided by 1, 2, 4 or 8 in a prescaler. When the counter wraps it sets a sticky overflow flag, and this flag can raise an interrupt.

The control register has a wide-access mode bit. When that bit is set, the high-byte address reaches a shadow byte and not the live counter high byte. A low-byte read captures the live high byte into the shadow byte. A low-byte write commits the shadow byte into the counter high byte. Software can therefore read or load all 16 bits as one value, even while the counter runs. An external event input clears the count, so a compare unit outside the block can use this input to make the timer periodic.

Address map: 0 control, 1 count low byte, 2 count high byte (or the shadow byte), 3 status. Control bits: [0] run enable, [2:1] prescale select, [3] external tick source, [7] wide-access mode. Other control bits read 0. Status bits: [0] overflow flag, [1] interrupt enable.

Top module: `byte_timer16`

## Requirements
- R1: After reset, the control register, the status register, the count and the shadow byte all read 0, and irq_o is low.
- R2: In wide mode, a read of address 1 copies the live count high byte into the shadow byte at the same clock edge. Later reads of address 2 return that copy, even after the counter has moved on.
- R3: In wide mode, a write to address 2 loads only the shadow byte and leaves the live high byte unchanged. A write to address 1 loads the low byte and moves the shadow byte into the high byte at the same edge.
- R4: With wide mode off, reads and writes of address 2 reach the live count high byte directly.
- R5: With run enable set, the count rises by one every 2^s selected ticks, where s is control bits [2:1]. With run enable clear, the count holds.
- R6: A write to address 2 leaves the prescaler phase unchanged. Any write to address 1 clears the prescaler phase.
- R7: When the count increments from FFFFh to 0000h, status bit 0 is set. It stays set until software writes 0 to it. Writing 1 to it has no effect.
- R8: irq_o is high exactly when status bit 0 and status bit 1 are both set.
- R9: A high level on evt_reset_i clears the count to 0000h at the next edge, and it does not set status bit 0.
- R10: When a counter write (address 1, or address 2 with wide mode off) and evt_reset_i fall in the same cycle, the written value is kept.
- R11: With control bit 3 set, the counter uses ext_tick_i after a two-stage synchronizer. It counts one tick for each rising edge, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| ext_tick_i | input | 1 | External tick, asynchronous to clk_i |
| evt_reset_i | input | 1 | Event input that clears the count |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two functions can act in the same cycle: a bus write to the counter and the event clear. The bench raises evt_reset_i during the same cycle that carries a low-byte write strobe. It then reads the low byte back and expects the written byte, not zero. A second pair also shares a cycle: a wide-mode low-byte read and the capture of the high byte into the shadow byte. The bench checks this pair by letting the counter carry into the high byte after the read, then comparing the shadow byte against the live byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CNT_HI = 2'd2,
    ADDR_STAT   = 2'd3
  } tmr_addr_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_PRE  = 1;
  localparam int unsigned CTRL_EXT  = 3;
  localparam int unsigned CTRL_WIDE = 7;
  localparam int unsigned STAT_FLAG = 0;
  localparam int unsigned STAT_IE   = 1;

  typedef struct packed {
    logic             wide;
    logic             ext;
    logic [SEL_W-1:0] pre;
    logic             en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned PRE_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(sel_i)) mask[i] = 1'b1;
  end

  assign pulse_o = en_i & tick_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + 1'b1;

  // divide ratios above one never give two pulses in a row
  assert_no_back_to_back_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && sel_i != '0) |=> (!pulse_o || sel_i == '0));
  assert_clear_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              rd_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              inc_i,
  input  logic              evt_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [BYTE_W-1:0] shadow_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0]  count_q;
  logic [BYTE_W-1:0] shadow_q;
  logic              wr_cnt;

  assign wr_cnt = wr_lo_i | (wr_hi_i & ~wide_i);
  assign wrap_o = inc_i & ~wr_cnt & ~evt_i & (count_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 shadow_q <= '0;
    else if (wide_i && wr_hi_i)  shadow_q <= wdata_i;
    else if (wide_i && rd_lo_i)  shadow_q <= count_q[CNT_W-1:BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) count_q <= '0;
    else if (wr_lo_i) begin
      count_q[BYTE_W-1:0] <= wdata_i;
      if (wide_i) count_q[CNT_W-1:BYTE_W] <= shadow_q;
    end
    else if (wr_hi_i && !wide_i) count_q[CNT_W-1:BYTE_W] <= wdata_i;
    else if (evt_i)              count_q <= '0;
    else if (inc_i)              count_q <= count_q + 1'b1;

  assign count_o  = count_q;
  assign shadow_o = shadow_q;

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && rd_lo_i && !wr_hi_i) |=> shadow_q == $past(count_q[CNT_W-1:BYTE_W]));
  assert_wide_hi_only_shadow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && wr_hi_i && !wr_lo_i && !evt_i && !inc_i) |=> $stable(count_q));
  assert_evt_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !wr_cnt) |=> count_q == '0);
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && evt_i) |=> count_q[BYTE_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic              ext_tick_i,
  input  logic              evt_reset_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  tmr_ctrl_t         ctrl_q;
  logic              flag_q, ie_q;
  logic              wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
  logic              ext_rise, tick, step, wrap;
  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] shadow;

  assign wr_ctrl = bus_wr_i & (bus_addr_i == ADDR_CTRL);
  assign wr_lo   = bus_wr_i & (bus_addr_i == ADDR_CNT_LO);
  assign wr_hi   = bus_wr_i & (bus_addr_i == ADDR_CNT_HI);
  assign wr_stat = bus_wr_i & (bus_addr_i == ADDR_STAT);
  assign rd_lo   = bus_rd_i & (bus_addr_i == ADDR_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.en   <= bus_wdata_i[CTRL_EN];
      ctrl_q.pre  <= bus_wdata_i[CTRL_PRE +: SEL_W];
      ctrl_q.ext  <= bus_wdata_i[CTRL_EXT];
      ctrl_q.wide <= bus_wdata_i[CTRL_WIDE];
    end

  // wrap sets; only an explicit zero clears; set wins a tie
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= wrap | (flag_q & ~(wr_stat & ~bus_wdata_i[STAT_FLAG]));
      if (wr_stat) ie_q <= bus_wdata_i[STAT_IE];
    end

  tmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_tick_i),
    .rise_o  (ext_rise)
  );

  assign tick = ctrl_q.ext ? ext_rise : 1'b1;

  tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_q.en),
    .tick_i  (tick),
    .clr_i   (wr_lo),
    .sel_i   (ctrl_q.pre),
    .pulse_o (step)
  );

  tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wide_i   (ctrl_q.wide),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .rd_lo_i  (rd_lo),
    .wdata_i  (bus_wdata_i),
    .inc_i    (step),
    .evt_i    (evt_reset_i),
    .count_o  (count),
    .shadow_o (shadow),
    .wrap_o   (wrap)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_CTRL: begin
        bus_rdata_o[CTRL_EN]             = ctrl_q.en;
        bus_rdata_o[CTRL_PRE +: SEL_W]   = ctrl_q.pre;
        bus_rdata_o[CTRL_EXT]            = ctrl_q.ext;
        bus_rdata_o[CTRL_WIDE]           = ctrl_q.wide;
      end
      ADDR_CNT_LO: bus_rdata_o = count[BYTE_W-1:0];
      ADDR_CNT_HI: bus_rdata_o = ctrl_q.wide ? shadow : count[CNT_W-1:BYTE_W];
      ADDR_STAT: begin
        bus_rdata_o[STAT_FLAG] = flag_q;
        bus_rdata_o[STAT_IE]   = ie_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & ie_q;

  assert_flag_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(step && count == '1 && !evt_reset_i));
  assert_flag_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(wr_stat && !bus_wdata_i[STAT_FLAG]));
  assert_evt_no_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_reset_i && !flag_q) |=> !flag_q);
  assert_hold_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !bus_wr_i && !evt_reset_i) |=> $stable(count));
endmodule

// File: tb/byte_timer16_bench.sv
`timescale 1ns/1ps
module byte_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext = 1'b0, evt = 1'b0;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  byte_timer16 u_byte_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_tick_i(ext),
    .evt_reset_i(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input logic with_evt = 1'b0);
    addr = a; wdata = d; wr = 1'b1; evt = with_evt;
    @(negedge clk);
    wr = 1'b0; evt = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(0, v); chk("R1 ctrl", v, 8'h00);
    rd_reg(1, v); chk("R1 low", v, 8'h00);
    rd_reg(2, v); chk("R1 high", v, 8'h00);
    rd_reg(3, v); chk("R1 stat", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_wide_write;
    logic [7:0] v;
    wr_reg(0, 8'h80);
    wr_reg(2, 8'h34);
    rd_reg(2, v); chk("R3 shadow loaded", v, 8'h34);
    wr_reg(0, 8'h00);
    rd_reg(2, v); chk("R3 live high untouched", v, 8'h00);
    wr_reg(0, 8'h80);
    wr_reg(1, 8'h56);
    wr_reg(0, 8'h00);
    rd_reg(2, v); chk("R3 high committed", v, 8'h34);
    rd_reg(1, v); chk("R3 low written", v, 8'h56);
  endtask

  task automatic t_wide_read;
    logic [7:0] v;
    wr_reg(0, 8'h80);
    wr_reg(2, 8'h12);
    wr_reg(1, 8'hFF);
    rd_reg(1, v); chk("R2 low", v, 8'hFF);
    wr_reg(0, 8'h81);
    wr_reg(0, 8'h80);        // one tick: 12FF -> 1300
    rd_reg(2, v); chk("R2 shadow keeps capture", v, 8'h12);
    rd_reg(1, v); chk("R2 low after carry", v, 8'h00);
    rd_reg(2, v); chk("R2 recapture", v, 8'h13);
  endtask

  task automatic t_narrow;
    logic [7:0] v;
    wr_reg(0, 8'h00);
    wr_reg(2, 8'hA5);
    rd_reg(2, v); chk("R4 direct high", v, 8'hA5);
    rd_reg(1, v); chk("R4 low untouched", v, 8'h00);
  endtask

  task automatic t_prescale;
    logic [7:0] v;
    for (int s = 0; s < 4; s++) begin
      wr_reg(0, 8'h00);
      wr_reg(1, 8'h00);
      wr_reg(2, 8'h00);
      wr_reg(0, 8'(s << 1) | 8'h01);
      idle(14);
      wr_reg(0, 8'h00);       // 15 ticks
      rd_reg(1, v); chk($sformatf("R5 divide sel %0d", s), v, 8'(15 >> s));
    end
    idle(10);
    rd_reg(1, v); chk("R5 hold when disabled", v, 8'h01);
  endtask

  task automatic t_pre_clear;
    logic [7:0] v;
    wr_reg(0, 8'h00); wr_reg(1, 8'h00); wr_reg(2, 8'h00);
    wr_reg(0, 8'h05); idle(1); wr_reg(0, 8'h00);   // 2 ticks at divide 4
    wr_reg(2, 8'h00);
    wr_reg(0, 8'h05); idle(1); wr_reg(0, 8'h00);   // 2 more
    rd_reg(1, v); chk("R6 high write keeps phase", v, 8'h01);
    wr_reg(1, 8'h00);
    wr_reg(0, 8'h05); idle(1); wr_reg(0, 8'h00);
    wr_reg(1, 8'h00);
    wr_reg(0, 8'h05); idle(1); wr_reg(0, 8'h00);
    rd_reg(1, v); chk("R6 low write clears phase", v, 8'h00);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    wr_reg(3, 8'h00);
    wr_reg(1, 8'hFF); wr_reg(2, 8'hFF);
    wr_reg(0, 8'h01); wr_reg(0, 8'h00);
    rd_reg(1, v); chk("R7 wrap low", v, 8'h00);
    rd_reg(2, v); chk("R7 wrap high", v, 8'h00);
    idle(5);
    rd_reg(3, v); chk("R7 flag sticky", v, 8'h01);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    wr_reg(3, 8'h03);
    chk("R8 irq raised", {7'b0, irq}, 8'h01);
    rd_reg(3, v); chk("R7 write 1 no effect", v, 8'h03);
    wr_reg(3, 8'h02);
    rd_reg(3, v); chk("R7 flag cleared", v, 8'h02);
    chk("R8 irq dropped", {7'b0, irq}, 8'h00);
    wr_reg(3, 8'h00);
  endtask

  task automatic t_event;
    logic [7:0] v;
    wr_reg(1, 8'h40); wr_reg(2, 8'h21);
    evt = 1'b1; @(negedge clk); evt = 1'b0;
    rd_reg(1, v); chk("R9 low cleared", v, 8'h00);
    rd_reg(2, v); chk("R9 high cleared", v, 8'h00);
    rd_reg(3, v); chk("R9 no flag", v, 8'h00);
    wr_reg(1, 8'h40);
    wr_reg(1, 8'h77, 1'b1);
    rd_reg(1, v); chk("R10 write beats event", v, 8'h77);
  endtask

  task automatic t_ext;
    logic [7:0] v;
    wr_reg(0, 8'h00); wr_reg(1, 8'h00); wr_reg(2, 8'h00);
    wr_reg(0, 8'h09);
    idle(4);
    for (int i = 0; i < 3; i++) begin
      #1 ext = 1'b1; idle(3 + 4 * i);
      #1 ext = 1'b0; idle(3);
    end
    idle(4);
    wr_reg(0, 8'h00);
    rd_reg(1, v); chk("R11 one count per rising edge", v, 8'h03);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_wide_write();
    t_wide_read();
    t_narrow();
    t_prescale();
    t_pre_clear();
    t_overflow();
    t_event();
    t_ext();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule